// File: doc/BRIEF.md
# Character Display Command Executor

This block is the instruction-execution core of a character display controller. The host writes bytes with a register-select bit. With the select bit low the byte is a command. With the select bit high it is a character to store. The block holds an 80-byte display memory, an address counter, a flag that records which memory the counter addresses, an entry mode (a step direction and a shift enable), and a display shift offset that tells the panel scanner which memory cell sits at the left edge.

Three commands are decoded: clear, return home and entry-mode set. Clear blanks the whole display memory, one cell per clock, and raises a busy flag until it has finished. Every character write lands at the address counter. The counter then steps up or down. In shift mode the display offset steps in the same numeric direction, so the picture slides the opposite way and the cursor keeps its place on the panel. A combinational read port lets the panel scanner fetch any cell.

Top module: `char_exec`

## Requirements
- R1: After reset the address counter is 0, the shift offset is 0, the step direction is increment (`incMode`=1), shift mode is off (`shiftMode`=0), busy is low and the counter targets display memory (`dispTarget`=1).
- R2: A write accepted with `regSel`=1 stores `wrData` at the cell the address counter names. From the next cycle on, that value is seen on `rdData` when `rdAddr` selects the cell.
- R3: After each character write the address counter steps by +1 when `incMode`=1 and by -1 when `incMode`=0, modulo 80 (79 steps up to 0, and 0 steps down to 79).
- R4: With `shiftMode`=0 a character write leaves the shift offset unchanged.
- R5: With `shiftMode`=1 a character write steps the shift offset in the same numeric direction as the counter, modulo 80. The cursor position on the panel, (counter − offset) mod 80, therefore stays the same.
- R6: Command bytes 0x04 to 0x07 set `incMode` from bit 1 and `shiftMode` from bit 0. They leave the counter, the offset and the memory unchanged.
- R7: Command 0x01 raises busy for exactly 80 cycles, starting in the cycle after the write is accepted. Once the sweep ends, every display memory cell reads 0x20.
- R8: Command 0x01 also sets the counter and the offset to 0, sets `incMode`=1 and selects display memory. It leaves `shiftMode` unchanged.
- R9: Command bytes 0x02 and 0x03 set the counter and the offset to 0 and select display memory, without raising busy. The memory contents and the entry mode are left unchanged.
- R10: While busy is high, any write (command or character) is ignored.
- R11: Command bytes other than 0x01 to 0x07 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| regSel | input | 1 | 0 = command byte, 1 = character byte |
| wrData | input | 8 | Byte written |
| rdAddr | input | 7 | Display memory cell read by the scanner |
| rdData | output | 8 | Contents of the cell at `rdAddr` |
| busy | output | 1 | High while a clear sweep runs |
| addrCnt | output | 7 | Address counter |
| shiftOfs | output | 7 | Display shift offset |
| incMode | output | 1 | Step direction, 1 = increment |
| shiftMode | output | 1 | 1 = display shifts, 0 = cursor moves |
| dispTarget | output | 1 | 1 = counter addresses display memory |

## Verification
Every accepted write takes effect at the same clock edge that samples it. The counter, the offset, the mode bits and the stored cell are therefore due one edge later, and the bench samples them on the following falling edge. Busy is expected high on the 80 falling edges after a clear is accepted and low on the 81st. The scoreboard queues one busy item per cycle so the length of the sweep is checked exactly. Memory contents are read one cell per cycle through the read port, and each expected value is queued in the cycle the read address is applied.

// File: rtl/char_exec_pkg.sv
package char_exec_pkg;
  localparam int CE_DEPTH = 80;
  localparam int CE_AW    = $clog2(CE_DEPTH);
  localparam logic [7:0] CE_BLANK   = 8'h20;
  localparam logic [7:0] CE_CMD_CLR = 8'h01;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       dataWe;    // store dataByte at the address counter, then step
    logic [7:0] dataByte;
    logic       sweepWe;   // write blank at sweep address
    logic       homeRegs;  // counter and offset to 0, select display memory
    logic       forceInc;  // step direction back to increment
    logic       modeWe;    // load entry mode
    logic [1:0] modeBits;  // {inc, shift}
  } ceStrobe_t;
endpackage

// File: rtl/char_exec_ctrl.sv
module char_exec_ctrl
  import char_exec_pkg::*;
#(
  parameter int DEPTH = CE_DEPTH,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          regSel,
  input  logic [7:0]    wrData,
  output logic          busy,
  output logic [AW-1:0] sweepAddr,
  output ceStrobe_t     strb
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busyQ;
  logic [AW-1:0] sweepQ;
  logic          clrStart;

  assign clrStart  = wrEn && !busyQ && !regSel && (wrData == CE_CMD_CLR);
  assign busy      = busyQ;
  assign sweepAddr = sweepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      sweepQ <= '0;
    end else if (clrStart) begin
      busyQ  <= 1'b1;
      sweepQ <= '0;
    end else if (busyQ) begin
      if (sweepQ == LAST) begin
        busyQ  <= 1'b0;
        sweepQ <= '0;
      end else begin
        sweepQ <= sweepQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb = '0;
    if (busyQ) begin
      strb.sweepWe = 1'b1;
    end else if (wrEn) begin
      if (regSel) begin
        strb.dataWe   = 1'b1;
        strb.dataByte = wrData;
      end else begin
        casez (wrData)
          8'b0000_0001: begin
            strb.homeRegs = 1'b1;
            strb.forceInc = 1'b1;
          end
          8'b0000_001?: strb.homeRegs = 1'b1;
          8'b0000_01??: begin
            strb.modeWe   = 1'b1;
            strb.modeBits = wrData[1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/char_exec_dp.sv
module char_exec_dp
  import char_exec_pkg::*;
#(
  parameter int DEPTH = CE_DEPTH,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ceStrobe_t     strb,
  input  logic [AW-1:0] sweepAddr,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic [AW-1:0] addrCnt,
  output logic [AW-1:0] shiftOfs,
  output logic          incMode,
  output logic          shiftMode,
  output logic          dispTarget
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] acQ, ofsQ;
  logic          incQ, shfQ, tgtQ;

  function automatic logic [AW-1:0] stepMod(input logic [AW-1:0] v, input logic up);
    if (up) return (v == LAST) ? '0 : v + 1'b1;
    else    return (v == '0) ? LAST : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.sweepWe)     mem[sweepAddr] <= CE_BLANK;
    else if (strb.dataWe) mem[acQ]       <= strb.dataByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acQ  <= '0;
      ofsQ <= '0;
      incQ <= 1'b1;
      shfQ <= 1'b0;
      tgtQ <= 1'b1;
    end else begin
      if (strb.homeRegs) begin
        acQ  <= '0;
        ofsQ <= '0;
        tgtQ <= 1'b1;
      end
      if (strb.forceInc) incQ <= 1'b1;
      if (strb.modeWe) {incQ, shfQ} <= strb.modeBits;
      if (strb.dataWe) begin
        acQ <= stepMod(acQ, incQ);
        if (shfQ) ofsQ <= stepMod(ofsQ, incQ);
      end
    end
  end

  assign rdData     = (rdAddr <= LAST) ? mem[rdAddr] : CE_BLANK;
  assign addrCnt    = acQ;
  assign shiftOfs   = ofsQ;
  assign incMode    = incQ;
  assign shiftMode  = shfQ;
  assign dispTarget = tgtQ;
endmodule

// File: rtl/char_exec.sv
module char_exec
  import char_exec_pkg::*;
#(
  parameter int DEPTH = CE_DEPTH,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          regSel,
  input  logic [7:0]    wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          busy,
  output logic [AW-1:0] addrCnt,
  output logic [AW-1:0] shiftOfs,
  output logic          incMode,
  output logic          shiftMode,
  output logic          dispTarget
);
  ceStrobe_t     strb;
  logic [AW-1:0] sweepAddr;

  char_exec_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .busy(busy), .sweepAddr(sweepAddr), .strb(strb)
  );

  char_exec_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sweepAddr(sweepAddr),
    .rdAddr(rdAddr), .rdData(rdData), .addrCnt(addrCnt), .shiftOfs(shiftOfs),
    .incMode(incMode), .shiftMode(shiftMode), .dispTarget(dispTarget)
  );
endmodule

// File: rtl/char_exec_chk.sv
module char_exec_chk #(
  parameter int DEPTH = 80,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          regSel,
  input logic [7:0]    wrData,
  input logic          busy,
  input logic [AW-1:0] addrCnt,
  input logic [AW-1:0] shiftOfs,
  input logic          incMode,
  input logic          shiftMode
);
  localparam int LAST = DEPTH - 1;

  logic          takeData, takeCmd;
  logic [AW-1:0] panelPos;
  int            busyRun;

  assign takeData = wrEn && !busy && regSel;
  assign takeCmd  = wrEn && !busy && !regSel;
  assign panelPos = AW'((int'(addrCnt) + DEPTH - int'(shiftOfs)) % DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyRun <= 0;
    else                busyRun <= busyRun + 1;
  end

  // R3: counter steps up modulo depth
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rstN)
    takeData && incMode |=>
      int'(addrCnt) == ((int'($past(addrCnt)) == LAST) ? 0 : int'($past(addrCnt)) + 1));

  // R3: counter steps down modulo depth
  a_r3_step_dn: assert property (@(posedge clk) disable iff (!rstN)
    takeData && !incMode |=>
      int'(addrCnt) == ((int'($past(addrCnt)) == 0) ? LAST : int'($past(addrCnt)) - 1));

  // R4: no shift in cursor mode
  a_r4_ofs_hold: assert property (@(posedge clk) disable iff (!rstN)
    takeData && !shiftMode |=> $stable(shiftOfs));

  // R5: panel position of the cursor is kept in shift mode
  a_r5_pos_kept: assert property (@(posedge clk) disable iff (!rstN)
    takeData && shiftMode |=> $stable(panelPos));

  // R7: sweep lasts exactly DEPTH cycles
  a_r7_sweep_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == DEPTH);

  // R9: home zeroes counter and offset without busy
  a_r9_home: assert property (@(posedge clk) disable iff (!rstN)
    takeCmd && wrData[7:1] == 7'h01 |=> addrCnt == '0 && shiftOfs == '0 && !busy);

  // R10: state frozen while busy
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(shiftOfs) && $stable(addrCnt) && $stable(shiftMode));
endmodule

bind char_exec char_exec_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .busy(busy), .addrCnt(addrCnt), .shiftOfs(shiftOfs),
  .incMode(incMode), .shiftMode(shiftMode)
);

// File: tb/char_exec_bench.sv
`timescale 1ns/10ps
module char_exec_bench;
  localparam int DEPTH = 80;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          regSel = 1'b0;
  logic [7:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          busy;
  logic [AW-1:0] addrCnt, shiftOfs;
  logic          incMode, shiftMode, dispTarget;

  always #2.5 clk = ~clk;

  char_exec u_char_exec (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .addrCnt(addrCnt),
    .shiftOfs(shiftOfs), .incMode(incMode), .shiftMode(shiftMode),
    .dispTarget(dispTarget)
  );

  typedef enum int {F_AC, F_OFS, F_INC, F_SHF, F_BUSY, F_TGT, F_RD} fld_t;
  typedef struct {
    string req;
    fld_t  fld;
    int    addr;
    int    val;
  } item_t;

  item_t queueQ[$];
  int    nTests = 0;
  int    nFail  = 0;
  bit    done   = 0;

  // reference model
  int mAc = 0, mOfs = 0, mInc = 1, mShf = 0;
  int mMem [DEPTH];

  function automatic int modStep(int v, int up);
    if (up != 0) return (v == DEPTH - 1) ? 0 : v + 1;
    return (v == 0) ? DEPTH - 1 : v - 1;
  endfunction

  task automatic push(string req, fld_t f, int val, int addr = 0);
    item_t it;
    it.req = req; it.fld = f; it.val = val; it.addr = addr;
    queueQ.push_back(it);
  endtask

  task automatic pushRegs(string req);
    push(req, F_AC, mAc);
    push(req, F_OFS, mOfs);
    push(req, F_INC, mInc);
    push(req, F_SHF, mShf);
  endtask

  // one cycle: drive after the falling edge, release after the rising edge
  task automatic step(bit en, bit rs, logic [7:0] d);
    @(negedge clk); #1;
    wrEn = en; regSel = rs; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic putChar(logic [7:0] d, string req);
    step(1'b1, 1'b1, d);
    mMem[mAc] = int'(d);
    if (mShf != 0) mOfs = modStep(mOfs, mInc);
    mAc = modStep(mAc, mInc);
    pushRegs(req);
  endtask

  task automatic scanAll(string req);
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b0, 8'h00);
      push(req, F_RD, mMem[a], a);
    end
  endtask

  task automatic clearRun(bit poke);
    step(1'b1, 1'b0, 8'h01);
    mAc = 0; mOfs = 0; mInc = 1;
    push("R7", F_BUSY, 1);
    pushRegs("R8");
    push("R8", F_TGT, 1);
    for (int i = 1; i < DEPTH; i++) begin
      if (poke && i == 40) step(1'b1, 1'b1, 8'h55);
      else if (poke && i == 50) step(1'b1, 1'b0, 8'h06);
      else step(1'b0, 1'b0, 8'h00);
      push("R7", F_BUSY, 1);
    end
    for (int a = 0; a < DEPTH; a++) mMem[a] = 32'h20;
    step(1'b0, 1'b0, 8'h00);
    push("R7", F_BUSY, 0);
    pushRegs("R10");
  endtask

  // monitor: compare queued items at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (queueQ.size() > 0) begin
        item_t it;
        int act;
        it = queueQ.pop_front();
        case (it.fld)
          F_AC:   act = int'(addrCnt);
          F_OFS:  act = int'(shiftOfs);
          F_INC:  act = int'(incMode);
          F_SHF:  act = int'(shiftMode);
          F_BUSY: act = int'(busy);
          F_TGT:  act = int'(dispTarget);
          default: begin
            rdAddr = AW'(it.addr);
            #0.01;
            act = int'(rdData);
          end
        endcase
        nTests++;
        if (act !== it.val) begin
          nFail++;
          $display("FAIL %s field %s addr %0d: actual %0d expected %0d",
                   it.req, it.fld.name(), it.addr, act, it.val);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mMem[a] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    pushRegs("R1");
    push("R1", F_BUSY, 0);
    push("R1", F_TGT, 1);

    // clear with ignored writes mid-sweep (R10), then full scan
    clearRun(1'b1);
    scanAll("R7");

    // increment, cursor mode
    putChar(8'h41, "R2");
    putChar(8'h42, "R3");
    // entry mode: decrement, no shift
    step(1'b1, 1'b0, 8'h04); mInc = 0; mShf = 0; pushRegs("R6");
    putChar(8'h43, "R4");
    putChar(8'h44, "R3");
    putChar(8'h45, "R3");   // 0 -> 79 wrap
    // entry mode: increment, shift
    step(1'b1, 1'b0, 8'h07); mInc = 1; mShf = 1; pushRegs("R6");
    putChar(8'h46, "R5");   // 79 -> 0
    putChar(8'h47, "R5");
    // entry mode: decrement, shift
    step(1'b1, 1'b0, 8'h05); mInc = 0; mShf = 1; pushRegs("R6");
    putChar(8'h48, "R5");
    putChar(8'h49, "R5");
    putChar(8'h4a, "R5");   // offset 0 -> 79 wrap

    // unlisted commands
    step(1'b1, 1'b0, 8'h00); pushRegs("R11");
    step(1'b1, 1'b0, 8'h08); pushRegs("R11");
    step(1'b1, 1'b0, 8'h81); pushRegs("R11");
    step(1'b1, 1'b0, 8'hff); pushRegs("R11"); push("R11", F_BUSY, 0);
    step(1'b0, 1'b0, 8'h00); push("R2", F_RD, mMem[1], 1);
    step(1'b0, 1'b0, 8'h00); push("R2", F_RD, mMem[79], 79);

    // home, both encodings
    step(1'b1, 1'b0, 8'h03); mAc = 0; mOfs = 0; pushRegs("R9");
    push("R9", F_BUSY, 0); push("R9", F_TGT, 1);
    putChar(8'h4b, "R2");
    step(1'b1, 1'b0, 8'h02); mAc = 0; mOfs = 0; pushRegs("R9");
    scanAll("R9");

    // clear keeps shift mode, forces increment
    clearRun(1'b0);
    step(1'b0, 1'b0, 8'h00); push("R8", F_RD, 32'h20, 2);
    step(1'b0, 1'b0, 8'h00); push("R8", F_SHF, 1);
    step(1'b0, 1'b0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule